// File: doc/BRIEF.md
# UART Oversampling Tick Generator

This block makes the 16x oversampling enable for a serial transmitter and receiver. It turns a stream of source enable pulses into a stream of single-cycle ticks. Two sources are offered: an internal clock enable and an external serial clock enable. The external enable must already be synchronised to the system clock. A two-bit source select chooses one of the two sources. It also chooses whether that source drives the tick directly or goes first through a two-stage divider. The first stage is a power-of-four prescaler, and the second is an 8-bit divisor.

Software programs the block through a small register port with two words. The mode word holds the source select. The rate word holds the divisor and the prescaler select. Each counter stage reads its reload value from the register when it reloads, so a write never cuts a running count short. After reset the divider waits for one source pulse, which only loads the counters, and then starts counting.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset `tick` is low and both register words read back as zero.
- R2: Address 0 is the mode word, and its bits 6:5 hold the source select. Address 1 is the rate word: bits 7:0 hold the divisor and bits 9:8 the prescaler select. Every other bit reads as zero. Read data appears on `reg_rdata` one cycle after `reg_addr` is presented.
- R3: The source select codes are: 0 gives the internal enable direct, 1 the internal enable through the divider, 2 the external enable direct, and 3 the external enable through the divider. Pulses on the enable that is not selected produce no tick and do not advance the count.
- R4: In a direct mode, each selected source pulse gives exactly one tick, in the cycle after the pulse.
- R5: In a divider mode, a tick is issued on every P*D-th selected pulse, one cycle after that pulse. P is 1, 4, 16 or 64 for prescaler select 0, 1, 2 or 3, and D is the divisor.
- R6: A divisor of 0 behaves as a divisor of 1.
- R7: After reset, the first selected pulse in a divider mode only loads the counters and gives no tick. Counting starts with the next pulse.
- R8: A new divisor takes effect at the next divisor reload. A write that lands in the same cycle as a reload applies only from the reload after that.
- R9: `tick` is never high in a cycle that does not follow a selected source pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Word select: 0 = mode, 1 = rate |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| int_en | input | 1 | Internal clock enable pulse |
| ext_en | input | 1 | External serial clock enable, already synchronised |
| tick | output | 1 | Registered oversampling tick |

## Verification
The sharp case is a rate-word write that lands in the same clock cycle as the divisor reload that produces a tick. The reload must take the old divisor, and the new one must apply only one period later. The bench provokes this by driving the write strobe together with the source pulse that completes a period. It then checks the exact pulse numbers of the next ticks against old-then-new periods. A write issued in the middle of a count is also checked: the period in progress must finish unchanged.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef enum logic [1:0] {
    SRC_INT_DIRECT = 2'd0,
    SRC_INT_GEN    = 2'd1,
    SRC_EXT_DIRECT = 2'd2,
    SRC_EXT_GEN    = 2'd3
  } src_sel_e;

  // Terminal count of the prescaler for a given select: ratio 4**sel, minus one.
  function automatic int unsigned prescale_last(input int unsigned sel);
    return (32'd1 << (2 * sel)) - 32'd1;
  endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8,
  parameter int PSEL_W  = 2,
  parameter int SRC_LSB = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output baud_gen_pkg::src_sel_e src_sel,
  output logic [DIV_W-1:0]      divisor,
  output logic [PSEL_W-1:0]     psel
);
  import baud_gen_pkg::*;

  localparam int RATE_W = DIV_W + PSEL_W;

  src_sel_e          mode_q;
  logic [RATE_W-1:0] rate_q;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SRC_INT_DIRECT;
      rate_q <= '0;
    end else if (wr_en) begin
      if (addr) rate_q <= wdata[RATE_W-1:0];
      else      mode_q <= src_sel_e'(wdata[SRC_LSB +: 2]);
    end
  end

  always_comb begin
    rdata_d = '0;
    if (addr) rdata_d[RATE_W-1:0]   = rate_q;
    else      rdata_d[SRC_LSB +: 2] = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rdata_d;
  end

  assign src_sel = mode_q;
  assign divisor = rate_q[DIV_W-1:0];
  assign psel    = rate_q[RATE_W-1:DIV_W];

  // R2: a rate write is visible in the stored word on the next cycle
  p_rate_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr) |=> (rate_q == $past(wdata[RATE_W-1:0])));

  // R2: a mode write leaves the rate word untouched
  p_mode_write_keeps_rate_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr) |=> $stable(rate_q));

endmodule

// File: rtl/baud_count_stage.sv
module baud_count_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] last_val,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = step && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= last_val;
    end else if (step) begin
      if (cnt == '0) cnt <= last_val;
      else           cnt <= cnt - 1'b1;
    end
  end

  // R5: a step on a non-terminal count moves the count down by one
  p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R3: without a step or load the count holds
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(cnt));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8,
  parameter int PSEL_W  = 2,
  parameter int SRC_LSB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              int_en,
  input  logic              ext_en,
  output logic              tick
);
  import baud_gen_pkg::*;

  localparam int PRE_W = 2 * ((1 << PSEL_W) - 1);

  src_sel_e          src_sel;
  logic [DIV_W-1:0]  divisor;
  logic [PSEL_W-1:0] psel;
  logic              src_en;
  logic              gen_mode;
  logic              primed;
  logic              prime_load;
  logic              pre_step;
  logic              pre_done;
  logic              div_done;
  logic [PRE_W-1:0]  pre_last;
  logic [DIV_W-1:0]  div_last;
  logic              tick_d;

  baud_regs #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .PSEL_W (PSEL_W),
    .SRC_LSB(SRC_LSB)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .src_sel(src_sel),
    .divisor(divisor),
    .psel   (psel)
  );

  assign src_en     = src_sel[1] ? ext_en : int_en;
  assign gen_mode   = src_sel[0];
  assign prime_load = gen_mode && src_en && !primed;
  assign pre_step   = gen_mode && src_en && primed;
  assign pre_last   = PRE_W'(prescale_last(32'(psel)));
  assign div_last   = (divisor == '0) ? '0 : divisor - 1'b1;

  always_ff @(posedge clk) begin
    if (rst)             primed <= 1'b0;
    else if (prime_load) primed <= 1'b1;
  end

  baud_count_stage #(.W(PRE_W)) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .load    (prime_load),
    .step    (pre_step),
    .last_val(pre_last),
    .done    (pre_done)
  );

  baud_count_stage #(.W(DIV_W)) u_divide (
    .clk     (clk),
    .rst     (rst),
    .load    (prime_load),
    .step    (pre_done),
    .last_val(div_last),
    .done    (div_done)
  );

  assign tick_d = gen_mode ? div_done : src_en;

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= tick_d;
  end

  // R4: a selected pulse in a direct mode yields a tick next cycle
  p_direct_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (!gen_mode && src_en) |=> tick);

  // R7: the priming pulse gives no tick
  p_prime_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    prime_load |=> !tick);

  // R9: no tick without a selected source pulse in the cycle before
  p_tick_needs_src_r9: assert property (@(posedge clk) disable iff (rst)
    !src_en |=> !tick);

  // R5: the divisor stage only finishes on a prescaler completion
  p_div_after_pre_r5: assert property (@(posedge clk) disable iff (rst)
    div_done |-> pre_done);

endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        int_en = 1'b0;
  logic        ext_en = 1'b0;
  logic        tick;

  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  baud_tick_gen uut (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .int_en   (int_en),
    .ext_en   (ext_en),
    .tick     (tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input logic [15:0] exp, input string req);
    @(negedge clk); reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // One source pulse, optionally with a same-cycle rate write; returns the tick seen after it.
  task automatic pulse(input bit use_ext, input bit do_wr, input logic [15:0] wd, output logic tk);
    @(negedge clk);
    if (use_ext) ext_en = 1'b1; else int_en = 1'b1;
    reg_wr = do_wr; reg_addr = 1'b1; reg_wdata = wd;
    @(negedge clk);
    tk = tick;
    int_en = 1'b0; ext_en = 1'b0; reg_wr = 1'b0;
  endtask

  // n selected pulses, ticks expected on every multiple of period; optional unselected noise.
  task automatic measure(input bit use_ext, input int n, input int period, input bit noise, input string req);
    int mism = 0;
    int noisy = 0;
    logic tk;
    for (int i = 1; i <= n; i++) begin
      if (noise) begin
        pulse(!use_ext, 1'b0, 16'h0, tk);
        if (tk) noisy++;
      end
      pulse(use_ext, 1'b0, 16'h0, tk);
      if (tk != ((i % period) == 0)) mism++;
    end
    chk(mism == 0, req, mism, 0);
    if (noise) chk(noisy == 0, "R3 unselected source", noisy, 0);
    @(negedge clk);
    chk(tick == 1'b0, "R9 idle cycle", tick, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(tick == 1'b0, "R1 tick after reset", tick, 0);
    rd_chk(1'b0, 16'h0000, "R1 mode readback");
    rd_chk(1'b1, 16'h0000, "R1 rate readback");
  endtask

  task automatic t_regs();
    do_reset();
    wr(1'b0, 16'hFFFF);
    rd_chk(1'b0, 16'h0060, "R2 mode field");
    wr(1'b1, 16'hFFFF);
    rd_chk(1'b1, 16'h03FF, "R2 rate fields");
    rd_chk(1'b0, 16'h0060, "R2 mode kept");
  endtask

  task automatic t_direct();
    logic tk;
    do_reset();
    wr(1'b0, 16'h0000);               // internal direct
    measure(1'b0, 5, 1, 1'b0, "R4 internal direct");
    pulse(1'b1, 1'b0, 16'h0, tk);
    chk(tk == 1'b0, "R3 ext ignored in mode 0", tk, 0);
    wr(1'b0, 16'h0040);               // external direct
    measure(1'b1, 5, 1, 1'b0, "R4 external direct");
    pulse(1'b0, 1'b0, 16'h0, tk);
    chk(tk == 1'b0, "R3 int ignored in mode 2", tk, 0);
  endtask

  task automatic t_gen(input int ps, input int dv, input bit use_ext, input bit noise, input string req);
    logic tk;
    int p;
    p = 1 << (2 * ps);
    do_reset();
    wr(1'b1, 16'((ps << 8) | dv));
    wr(1'b0, use_ext ? 16'h0060 : 16'h0020);
    pulse(use_ext, 1'b0, 16'h0, tk);
    chk(tk == 1'b0, "R7 priming pulse", tk, 0);
    measure(use_ext, 2 * p * ((dv == 0) ? 1 : dv), p * ((dv == 0) ? 1 : dv), noise, req);
  endtask

  task automatic t_reload();
    logic tk;
    int mism = 0;
    bit exp;
    do_reset();
    wr(1'b1, 16'h0004);
    wr(1'b0, 16'h0020);
    pulse(1'b0, 1'b0, 16'h0, tk);
    for (int i = 1; i <= 15; i++) begin
      bit w;
      logic [15:0] d;
      w = (i == 2) || (i == 8);
      d = (i == 2) ? 16'h0002 : 16'h0005;
      pulse(1'b0, w, d, tk);
      exp = (i == 4) || (i == 6) || (i == 8) || (i == 10) || (i == 15);
      if (tk != exp) begin
        mism++;
        $display("FAIL R8 pulse %0d actual=%0d expected=%0d", i, tk, exp);
      end
    end
    chk(mism == 0, "R8 reload timing", mism, 0);
  endtask

  initial begin
    #1000000;
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_regs();
    t_direct();
    t_gen(0, 1, 1'b0, 1'b0, "R5 P1 D1 internal");
    t_gen(0, 5, 1'b1, 1'b0, "R5 P1 D5 external");
    t_gen(1, 3, 1'b0, 1'b1, "R5 P4 D3 internal with noise");
    t_gen(2, 2, 1'b1, 1'b1, "R5 P16 D2 external with noise");
    t_gen(3, 2, 1'b0, 1'b0, "R5 P64 D2 internal");
    t_gen(0, 0, 1'b0, 1'b0, "R6 divisor zero P1");
    t_gen(1, 0, 1'b1, 1'b0, "R6 divisor zero P4");
    t_reload();
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule